// File: doc/BRIEF.md
# Winograd Tile Window Buffer

This block sits between a memory-read stream and a Winograd F(2×2,3×3) convolution engine. It receives a feature map two rows at a time, with each input beat holding one element of each of the two rows, and turns that raster stream into overlapping 4×4 tiles. Vertically, tiles step by two pixels. Horizontally, they also step by two pixels. Each output beat carries one complete 4×4 tile for one channel. All channels of a tile position leave before the window moves on.

Four single-row memories hold the window. A vertical step reloads only the two memories that hold the oldest rows, and the row roles rotate instead of data being copied between memories. A tile goes out as soon as the part of the newer row pair it needs has arrived, so output overlaps the load of that pair. Positions to the right of or below the map read as zero, so the last partial tile is complete.

A one-cycle `sof` pulse starts a frame and drops any frame still in progress. Both stream edges use valid/ready. A beat transfers on a rising clock edge where valid and ready are both high. A producer must hold valid and data steady until the transfer happens. Ready never depends on valid in the same cycle. `in_ready` falls whenever accepting another row pair would overwrite rows that pending tiles still need. `out_valid` stays high and `out_tile` stays unchanged until the consumer takes the tile.

Top module: `wtw_tile_window`

## Requirements
- R1: After reset, `in_ready` and `out_valid` stay low and no beat is accepted until `sof` is pulsed. A `sof` pulse starts a frame with no rows loaded.
- R2: Input beat layout: the low DW bits hold map row 2p and the high DW bits hold row 2p+1 of row pair p. Within a pair, beats run column by column, and within a column they run channel by channel. One pair therefore takes MAP_W·CH beats, and pairs arrive in increasing order.
- R3: Tile layout: element (i,j) of a tile, meaning tile row i and tile column j, sits at bits [(4i+j)·DW +: DW] of `out_tile`.
  - Tile (ty,tx) covers map rows 2ty..2ty+3 and columns 2tx..2tx+3.
  - There are (MAP_W−1)/2 tile columns and (MAP_H−1)/2 tile rows.
  - Output order: channel fastest, then tile column, then tile row.
- R4: Tile columns at index MAP_W or higher read as zero.
- R5: Tile rows at index MAP_H or higher read as zero. When MAP_H is odd, the high half of the last pair's beats is ignored.
- R6: Tile (ty,tx,c) is offered once pair ty is fully accepted and pair ty+1 has been accepted up to and including column min(2tx+3, MAP_W−1), channel c. With unbroken input, the first tile is offered right after MAP_W·CH + min(3,MAP_W−1)·CH + 1 accepted beats.
- R7: `in_ready` is low while the number of accepted pairs is at least the number of finished tile rows plus two.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_tile` does not change.
- R9: `out_last` is high with the final tile of a frame and only then. After that tile transfers, `in_ready` and `out_valid` stay low until the next `sof`.
- R10: A `sof` during a frame drops that frame's progress: on the next cycle `out_valid` is low and a fresh frame loads correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | One-cycle start-of-frame pulse |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept an input beat |
| in_data | input | 2*DW | Element of row 2p (low half) and row 2p+1 (high half) |
| out_valid | output | 1 | A tile is offered |
| out_ready | input | 1 | Consumer takes the offered tile |
| out_tile | output | 16*DW | 4×4 tile for one channel, row-major |
| out_last | output | 1 | Offered tile is the last of the frame |

## Verification
The checker assumes the following about the block's inputs:
- `in_valid` is low in any cycle that carries a `sof` pulse.
- Each frame's beats arrive in the order R2 gives.
- The producer holds a beat until it is taken.

Under those assumptions, the checker's own beat and tile counts must agree with the gating rules in R6 and R7. The bench keeps within these assumptions:
- It drives `in_valid` low around every `sof`.
- It offers beats strictly in pair, column, channel order.
- It inserts gaps only by lowering valid, never by changing a held beat.
- It stalls the output only by lowering `out_ready`.

// File: rtl/wtw_pkg.sv
package wtw_pkg;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_RUN  = 2'd1,
    FR_DONE = 2'd2
  } frame_st_t;

  // bits needed to hold values 0..n
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/wtw_row_mem.sv
module wtw_row_mem #(
  parameter int DW    = 8,
  parameter int MAP_W = 16,
  parameter int CH    = 4
) (
  input  logic                                        clk,
  input  logic                                        wr_en,
  input  logic [wtw_pkg::cnt_bits(MAP_W*CH)-1:0]      wr_addr,
  input  logic [DW-1:0]                               wr_data,
  input  logic [wtw_pkg::cnt_bits(MAP_W)-1:0]         rd_col,
  input  logic [wtw_pkg::cnt_bits(CH)-1:0]            rd_ch,
  output logic [4*DW-1:0]                             rd_word
);
  localparam int DEPTH = MAP_W * CH;
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[IW'(wr_addr)] <= wr_data;
  end

  // four adjacent columns of one channel; columns past the edge read zero
  for (genvar k = 0; k < 4; k++) begin : g_col
    logic [31:0] col_k;
    logic [31:0] idx_k;
    always_comb begin
      col_k = 32'(rd_col) + 32'(k);
      idx_k = col_k * 32'(CH) + 32'(rd_ch);
      if (col_k < 32'(MAP_W)) rd_word[k*DW +: DW] = mem[IW'(idx_k)];
      else                    rd_word[k*DW +: DW] = '0;
    end
  end

endmodule

// File: rtl/wtw_load_ctrl.sv
module wtw_load_ctrl #(
  parameter int MAP_W = 16,
  parameter int MAP_H = 16,
  parameter int CH    = 4
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         sof,
  input  logic                                         run,
  input  logic                                         in_valid,
  input  logic [wtw_pkg::cnt_bits((MAP_H-1)/2)-1:0]    rd_row,
  output logic                                         in_ready,
  output logic                                         wr_en,
  output logic [wtw_pkg::cnt_bits((MAP_H+1)/2)-1:0]    wr_pair,
  output logic [wtw_pkg::cnt_bits(MAP_W*CH)-1:0]       wr_pos
);
  localparam int BPP   = MAP_W * CH;
  localparam int NPAIR = (MAP_H + 1) / 2;
  localparam int PW    = wtw_pkg::cnt_bits(NPAIR);
  localparam int BW    = wtw_pkg::cnt_bits(BPP);

  logic pair_room;

  // a new pair may only land in the slots of a tile row already finished
  always_comb begin
    pair_room = (32'(wr_pair) < 32'(NPAIR)) &&
                (32'(wr_pair) < 32'(rd_row) + 32'd2);
    in_ready  = run && pair_room;
    wr_en     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sof) begin
      wr_pair <= '0;
      wr_pos  <= '0;
    end else if (wr_en) begin
      if (wr_pos == BW'(BPP - 1)) begin
        wr_pos  <= '0;
        wr_pair <= wr_pair + PW'(1);
      end else begin
        wr_pos  <= wr_pos + BW'(1);
      end
    end
  end

endmodule

// File: rtl/wtw_tile_ctrl.sv
module wtw_tile_ctrl #(
  parameter int MAP_W = 16,
  parameter int MAP_H = 16,
  parameter int CH    = 4
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         sof,
  input  logic                                         out_ready,
  input  logic [wtw_pkg::cnt_bits((MAP_H+1)/2)-1:0]    wr_pair,
  input  logic [wtw_pkg::cnt_bits(MAP_W*CH)-1:0]       wr_pos,
  output logic                                         out_valid,
  output logic                                         out_last,
  output logic                                         run,
  output logic [wtw_pkg::cnt_bits((MAP_H-1)/2)-1:0]    ty,
  output logic [wtw_pkg::cnt_bits((MAP_W-1)/2)-1:0]    tx,
  output logic [wtw_pkg::cnt_bits(CH)-1:0]             ch
);
  import wtw_pkg::*;

  localparam int TX = (MAP_W - 1) / 2;
  localparam int TY = (MAP_H - 1) / 2;
  localparam int XW = cnt_bits(TX);
  localparam int YW = cnt_bits(TY);
  localparam int CW = cnt_bits(CH);

  frame_st_t   st;
  logic [31:0] need_col;
  logic [31:0] need_idx;
  logic        top_ok;
  logic        bot_full;
  logic        bot_part;
  logic        at_end;

  assign run = (st == FR_RUN);

  // last element of the lower pair that this tile touches
  always_comb begin
    need_col = 32'(tx) * 32'd2 + 32'd3;
    if (need_col > 32'(MAP_W - 1)) need_col = 32'(MAP_W - 1);
    need_idx = need_col * 32'(CH) + 32'(ch);
    top_ok   = 32'(wr_pair) > 32'(ty);
    bot_full = 32'(wr_pair) > 32'(ty) + 32'd1;
    bot_part = (32'(wr_pair) == 32'(ty) + 32'd1) && (32'(wr_pos) > need_idx);
    out_valid = run && top_ok && (bot_full || bot_part);
    at_end   = (ch == CW'(CH - 1)) && (tx == XW'(TX - 1)) && (ty == YW'(TY - 1));
    out_last = out_valid && at_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= FR_IDLE;
      ty <= '0;
      tx <= '0;
      ch <= '0;
    end else if (sof) begin
      st <= FR_RUN;
      ty <= '0;
      tx <= '0;
      ch <= '0;
    end else if (out_valid && out_ready) begin
      if (ch == CW'(CH - 1)) begin
        ch <= '0;
        if (tx == XW'(TX - 1)) begin
          tx <= '0;
          if (ty == YW'(TY - 1)) st <= FR_DONE;
          else                   ty <= ty + YW'(1);
        end else begin
          tx <= tx + XW'(1);
        end
      end else begin
        ch <= ch + CW'(1);
      end
    end
  end

endmodule

// File: rtl/wtw_tile_assemble.sv
module wtw_tile_assemble #(
  parameter int DW    = 8,
  parameter int MAP_H = 16
) (
  input  logic [16*DW-1:0]                          slot_words,
  input  logic [1:0]                                base,
  input  logic [wtw_pkg::cnt_bits((MAP_H-1)/2)-1:0] ty,
  output logic [16*DW-1:0]                          tile
);
  // tile row i comes from slot (base+i) mod 4; rows past the map read zero
  for (genvar i = 0; i < 4; i++) begin : g_role
    logic [1:0]  slot_i;
    logic [31:0] map_row;
    always_comb begin
      slot_i  = base + 2'(i);
      map_row = 32'(ty) * 32'd2 + 32'(i);
      if (map_row < 32'(MAP_H)) tile[i*4*DW +: 4*DW] = slot_words[32'(slot_i)*4*DW +: 4*DW];
      else                      tile[i*4*DW +: 4*DW] = '0;
    end
  end

endmodule

// File: rtl/wtw_tile_window.sv
module wtw_tile_window #(
  parameter int DW    = 8,
  parameter int MAP_W = 16,
  parameter int MAP_H = 16,
  parameter int CH    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2*DW-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [16*DW-1:0] out_tile,
  output logic             out_last
);
  import wtw_pkg::*;

  localparam int BPP   = MAP_W * CH;
  localparam int TX    = (MAP_W - 1) / 2;
  localparam int TY    = (MAP_H - 1) / 2;
  localparam int NPAIR = (MAP_H + 1) / 2;
  localparam int PW    = cnt_bits(NPAIR);
  localparam int BW    = cnt_bits(BPP);
  localparam int XW    = cnt_bits(TX);
  localparam int YW    = cnt_bits(TY);
  localparam int CW    = cnt_bits(CH);
  localparam int COLW  = cnt_bits(MAP_W);

  logic             run;
  logic             wr_en;
  logic [PW-1:0]    wr_pair;
  logic [BW-1:0]    wr_pos;
  logic [YW-1:0]    ty;
  logic [XW-1:0]    tx;
  logic [CW-1:0]    ch;
  logic [COLW-1:0]  rd_col;
  logic [1:0]       base;
  logic [16*DW-1:0] slot_words;

  assign rd_col = COLW'(32'(tx) * 32'd2);
  assign base   = {ty[0], 1'b0};

  wtw_load_ctrl #(.MAP_W(MAP_W), .MAP_H(MAP_H), .CH(CH)) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .sof      (sof),
    .run      (run),
    .in_valid (in_valid),
    .rd_row   (ty),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_pair  (wr_pair),
    .wr_pos   (wr_pos)
  );

  wtw_tile_ctrl #(.MAP_W(MAP_W), .MAP_H(MAP_H), .CH(CH)) u_tile (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof       (sof),
    .out_ready (out_ready),
    .wr_pair   (wr_pair),
    .wr_pos    (wr_pos),
    .out_valid (out_valid),
    .out_last  (out_last),
    .run       (run),
    .ty        (ty),
    .tx        (tx),
    .ch        (ch)
  );

  // pair p writes slots 2*(p mod 2) (even row) and 2*(p mod 2)+1 (odd row)
  for (genvar k = 0; k < 4; k++) begin : g_slot
    localparam bit PAR = (k / 2) == 1;
    localparam bit HI  = (k % 2) == 1;
    logic          we_k;
    logic [DW-1:0] wd_k;
    assign we_k = wr_en && (wr_pair[0] == PAR);
    assign wd_k = HI ? in_data[2*DW-1:DW] : in_data[DW-1:0];

    wtw_row_mem #(.DW(DW), .MAP_W(MAP_W), .CH(CH)) u_mem (
      .clk     (clk),
      .wr_en   (we_k),
      .wr_addr (wr_pos),
      .wr_data (wd_k),
      .rd_col  (rd_col),
      .rd_ch   (ch),
      .rd_word (slot_words[k*4*DW +: 4*DW])
    );
  end

  wtw_tile_assemble #(.DW(DW), .MAP_H(MAP_H)) u_asm (
    .slot_words (slot_words),
    .base       (base),
    .ty         (ty),
    .tile       (out_tile)
  );

endmodule

// File: rtl/wtw_tile_window_chk.sv
module wtw_tile_window_chk #(
  parameter int DW    = 8,
  parameter int MAP_W = 16,
  parameter int MAP_H = 16,
  parameter int CH    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sof,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [16*DW-1:0] out_tile
);
  localparam int BPP  = MAP_W * CH;
  localparam int TX   = (MAP_W - 1) / 2;
  localparam int TY   = (MAP_H - 1) / 2;
  localparam int ROWT = TX * CH;

  logic        started;
  logic [31:0] beats_acc;
  logic [31:0] tiles_out;
  logic [31:0] rows_done;

  assign rows_done = tiles_out / 32'(ROWT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started   <= 1'b0;
      beats_acc <= '0;
      tiles_out <= '0;
    end else if (sof) begin
      started   <= 1'b1;
      beats_acc <= '0;
      tiles_out <= '0;
    end else begin
      if (in_valid && in_ready)   beats_acc <= beats_acc + 32'd1;
      if (out_valid && out_ready) tiles_out <= tiles_out + 32'd1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (!in_ready && !out_valid)); // R1

  AST_EARLY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !sof) |-> (beats_acc > (rows_done + 32'd1) * 32'(BPP))); // R6

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !sof) |-> (beats_acc < (rows_done + 32'd2) * 32'(BPP))); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !sof) |=> (out_valid && $stable(out_tile))); // R8

  AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (tiles_out == 32'(TY * ROWT - 1))); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !sof) |=> (!out_valid && !in_ready)); // R9

  AST_SOF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !out_valid); // R10

endmodule

bind wtw_tile_window wtw_tile_window_chk #(
  .DW(DW), .MAP_W(MAP_W), .MAP_H(MAP_H), .CH(CH)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sof       (sof),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .out_tile  (out_tile)
);

// File: tb/wtw_tile_window_tb_top.sv
module wtw_tile_window_tb_top;

  localparam int DW  = 8;
  localparam int W   = 7;
  localparam int H   = 7;
  localparam int CH  = 2;
  localparam int BPP = W * CH;
  localparam int TX  = (W - 1) / 2;
  localparam int TY  = (H - 1) / 2;
  localparam int NP  = (H + 1) / 2;
  localparam int NB  = NP * BPP;
  localparam int NT  = TX * TY * CH;
  localparam int TB  = 16 * DW;
  localparam int WD  = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sof = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2*DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [TB-1:0] out_tile;
  logic          out_last;

  int n_checks = 0;
  int n_fail   = 0;
  int acc_beats = 0;

  always #10 clk = ~clk;

  wtw_tile_window #(.DW(DW), .MAP_W(W), .MAP_H(H), .CH(CH)) dut_i (
    .clk (clk), .rst_n (rst_n), .sof (sof),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_tile (out_tile), .out_last (out_last)
  );

  always @(posedge clk) begin
    if (sof) acc_beats <= 0;
    else if (in_valid && in_ready) acc_beats <= acc_beats + 1;
  end

  function automatic logic [DW-1:0] pix(int seed, int r, int c, int ch);
    if (r >= H || c >= W) return '0;
    return DW'(r * 37 + c * 5 + ch * 11 + seed * 13 + 1);
  endfunction

  // R2: low half row 2p, high half row 2p+1 (filler when past the map)
  function automatic logic [2*DW-1:0] in_word(int seed, int p, int col, int ch);
    logic [DW-1:0] hi;
    hi = (2 * p + 1 < H) ? pix(seed, 2 * p + 1, col, ch) : DW'(165);
    return {hi, pix(seed, 2 * p, col, ch)};
  endfunction

  function automatic logic [TB-1:0] exp_tile(int seed, int ty, int tx, int ch);
    logic [TB-1:0] t;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        t[(i * 4 + j) * DW +: DW] = pix(seed, 2 * ty + i, 2 * tx + j, ch);
    return t;
  endfunction

  task automatic chk_int(string tag, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_tile(string tag, logic [TB-1:0] act, logic [TB-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s tile: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_sof();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
  endtask

  task automatic drive(int seed, int gap_mod, int nbeats);
    for (int b = 0; b < nbeats; b++) begin
      @(negedge clk);
      if (gap_mod != 0 && (b % gap_mod) == 1) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = in_word(seed, b / BPP, (b % BPP) / CH, b % CH);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic consume(int seed, int stall_mod, output int first_acc);
    int got = 0;
    int cyc = 0;
    logic held = 1'b0;
    logic [TB-1:0] prev = '0;
    first_acc = -1;
    while (got < NT) begin
      @(negedge clk);
      if (held) begin
        chk_int("R8", int'(out_valid), 1, "valid held under stall");
        chk_tile("R8", out_tile, prev);
      end
      out_ready = (stall_mod == 0) || ((cyc % stall_mod) != 0);
      cyc++;
      held = 1'b0;
      if (out_valid) begin
        if (first_acc < 0) first_acc = acc_beats;
        if (out_ready) begin
          int ty = got / (TX * CH);
          int tx = (got / CH) % TX;
          int c  = got % CH;
          string tag = (tx == TX - 1) ? "R4" : (ty == TY - 1) ? "R5" : "R3";
          chk_tile(tag, out_tile, exp_tile(seed, ty, tx, c));
          chk_int("R9", int'(out_last), int'(got == NT - 1), "last flag");
          got++;
        end else begin
          held = 1'b1;
          prev = out_tile;
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  // R1: quiet until sof, inputs refused
  task automatic t_idle();
    in_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk_int("R1", int'(in_ready), 0, "in_ready before sof");
    chk_int("R1", int'(out_valid), 0, "out_valid before sof");
    chk_int("R1", acc_beats, 0, "beats taken before sof");
    in_valid = 1'b0;
  endtask

  // R2 R3 R4 R5 R6 R9: full frame, no stalls
  task automatic t_basic();
    int first;
    pulse_sof();
    fork
      drive(1, 0, NB);
      consume(1, 0, first);
    join
    chk_int("R6", first, BPP + 3 * CH + 1, "beats accepted at first tile");
    repeat (4) begin
      @(negedge clk);
      chk_int("R9", int'(in_ready), 0, "in_ready after frame");
      chk_int("R9", int'(out_valid), 0, "out_valid after frame");
    end
  endtask

  // R7 R8: output held back, input gapped
  task automatic t_stall();
    int first;
    pulse_sof();
    fork
      drive(2, 3, NB);
      begin
        repeat (80) @(negedge clk);
        chk_int("R7", acc_beats, 2 * BPP, "beats accepted while output blocked");
        chk_int("R7", int'(in_ready), 0, "in_ready while output blocked");
        consume(2, 3, first);
      end
    join
  endtask

  // R10: abandon a frame part way and load a new one
  task automatic t_restart();
    int first;
    pulse_sof();
    drive(5, 0, 20);
    pulse_sof();
    chk_int("R10", int'(out_valid), 0, "out_valid after restart");
    chk_int("R10", acc_beats, 0, "beat count after restart");
    chk_int("R10", int'(in_ready), 1, "in_ready after restart");
    fork
      drive(3, 0, NB);
      consume(3, 2, first);
    join
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_int("R1", int'(in_ready), 0, "in_ready in reset");
    chk_int("R1", int'(out_valid), 0, "out_valid in reset");
    rst_n = 1'b1;
    t_idle();
    t_basic();
    t_stall();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule